// File: doc/BRIEF.md
# Receive Built-In Self-Test Character Checker

This block sits after the 8b/10b decoder of a receive lane and validates the link with a known test pattern. A remote transmitter repeats a pseudo-random sequence of 511 characters. The sequence is built from a 9-bit linear feedback shift register and covers data characters, special characters and violation symbols. This checker runs an identical generator. It stays idle until self-test is enabled and then looks for the loop start character D0.0. Once it locks on that character, it compares each following decoded character with its own generator.

A 3-bit status is returned for every input character, one clock after the character is accepted. A character flagged as a code or disparity violation is never reported as an error. When the last character of a loop arrives, the status reports once whether the loop was clean or had errors. After each loop the checker ignores a fixed number of word-sync characters. It drops lock when mismatches outnumber matches by a set margin.

Top module: `rx_bist_checker`

## Requirements
- R1: While `bist_en` is low, every accepted character gets status 111 (self-test off). The checker is held out of lock, so a later enable always starts by hunting.
- R2: While hunting, every accepted character gets status 001. Only a character with `chr_is_k`=0, `chr_data`=0 and `chr_viol`=0 (D0.0) ends the hunt. A D0.0 that carries the violation flag also gets 001.
- R3: The D0.0 that ends the hunt gets status 000. The generator starts at state 9'h1FF and steps as next = {s[7:0], s[8]^s[4]}, which is x^9+x^5+1. The expected character is the bitwise inverse of the state: bit 8 is the special flag and bits 7:0 are the data. The generator therefore never reaches zero.
- R4: In lock, a character that equals the expected character gets status 000. Any other character gets status 101.
- R5: In lock, a character with `chr_viol` high gets status 000 whatever its value, and the sequence still advances.
- R6: The 511th character of a loop (the one before the generator returns to 9'h1FF) gets status 010 if the loop had no mismatch, including that character. Otherwise it gets 100. This is reported exactly once per loop.
- R7: After each loop the next WSYNC_LEN characters (default 16) are skipped. They get status 000 whatever their value. The character after them is compared as the next loop's D0.0.
- R8: A difference counter adds one on each mismatch and subtracts one on each match, stopping at zero. The mismatch that brings it to ABORT_LIM (default 16) gets status 101 and sends the checker back to hunting with the generator reset.
- R9: `stat_vld` is high in exactly the cycle after each cycle in which `chr_vld` is high.
- R10: After reset, `stat_vld` is low, `stat_code` is 111 and the checker is out of lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bist_en | input | 1 | Self-test enable |
| chr_vld | input | 1 | Character strobe, one per character |
| chr_data | input | DATA_W (8) | Decoded character value |
| chr_is_k | input | 1 | Character is a special (control) code |
| chr_viol | input | 1 | Code-rule or disparity violation on this character |
| stat_vld | output | 1 | Status strobe |
| stat_code | output | 3 | Status code for the character |

## Verification
The hardest condition to reach is the abort. It needs the difference counter to climb all the way to its limit, and the counter stops at zero. The bench locks onto a loop and sends several correct characters first. This proves that matches taken at zero do not leave a hidden negative credit. It then sends exactly fifteen corrupted characters, which must still report a plain mismatch. The sixteenth corrupted character must be followed by hunt status, even for a character that fits the sequence.

// File: rtl/rx_bist_pkg.sv
package rx_bist_pkg;

   typedef enum logic [1:0] {
      ST_OFF  = 2'd0,
      ST_HUNT = 2'd1,
      ST_RUN  = 2'd2,
      ST_SKIP = 2'd3
   } chk_state_t;

   localparam logic [2:0] STS_GOOD   = 3'b000;
   localparam logic [2:0] STS_HUNT   = 3'b001;
   localparam logic [2:0] STS_PASS   = 3'b010;
   localparam logic [2:0] STS_FAILED = 3'b100;
   localparam logic [2:0] STS_MISS   = 3'b101;
   localparam logic [2:0] STS_OFF    = 3'b111;

endpackage

// File: rtl/rx_bist_lfsr.sv
module rx_bist_lfsr #(
   parameter int W   = 9,
   parameter int TAP = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   output logic [W-1:0] state_q,
   output logic [W-1:0] state_nxt
);
   localparam logic [W-1:0] SEED = '1;

   if (W < 3)
      $error("rx_bist_lfsr: W must be at least 3");
   if (TAP < 1 || TAP >= W)
      $error("rx_bist_lfsr: TAP out of range");

   assign state_nxt = {state_q[W-2:0], state_q[W-1] ^ state_q[TAP-1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    state_q <= SEED;
      else if (load) state_q <= SEED;
      else if (step) state_q <= state_nxt;
   end

   // R3: a maximal-length generator seeded non-zero never reaches zero
   a_r3_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != '0);

endmodule

// File: rtl/rx_bist_diff_cnt.sv
module rx_bist_diff_cnt #(
   parameter int LIMIT = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       inc,
   input  logic                       dec,
   output logic                       hit,
   output logic [$clog2(LIMIT)-1:0]   cnt_q
);
   localparam int CW = $clog2(LIMIT);

   if (LIMIT < 2)
      $error("rx_bist_diff_cnt: LIMIT must be at least 2");

   assign hit = inc && (cnt_q == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (clr || hit)         cnt_q <= '0;
      else if (inc)                cnt_q <= cnt_q + 1'b1;
      else if (dec && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   // R8: the difference never rests at the abort limit
   a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_q) < LIMIT);

   // R8: a match taken at zero leaves the counter at zero
   a_r8_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && dec && !inc && !clr) |=> (cnt_q == '0));

endmodule

// File: rtl/rx_bist_checker.sv
module rx_bist_checker
   import rx_bist_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int LFSR_TAP  = 5,
   parameter int ABORT_LIM = 16,
   parameter int WSYNC_LEN = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bist_en,
   input  logic              chr_vld,
   input  logic [DATA_W-1:0] chr_data,
   input  logic              chr_is_k,
   input  logic              chr_viol,
   output logic              stat_vld,
   output logic [2:0]        stat_code
);
   localparam int LFSR_W = DATA_W + 1;
   localparam logic [LFSR_W-1:0] SEED = '1;
   localparam int DCW = $clog2(ABORT_LIM);

   if (WSYNC_LEN < 0)
      $error("rx_bist_checker: WSYNC_LEN must not be negative");

   chk_state_t        state_q, state_d;
   logic [LFSR_W-1:0] lfsr_q, lfsr_nxt;
   logic              lfsr_load, lfsr_step;
   logic              diff_clr, diff_inc, diff_dec, diff_hit;
   logic [DCW-1:0]    diff_cnt;
   logic              err_q, err_d;
   logic              skip_done;
   logic [2:0]        code_d;
   logic [LFSR_W-1:0] rx_word, exp_word;
   logic              is_start, is_match, loop_last;

   assign rx_word   = {chr_is_k, chr_data};
   assign exp_word  = ~lfsr_q;
   assign is_start  = !chr_is_k && (chr_data == '0) && !chr_viol;
   assign is_match  = chr_viol || (rx_word == exp_word);
   assign loop_last = (lfsr_nxt == SEED);

   rx_bist_lfsr #(.W(LFSR_W), .TAP(LFSR_TAP)) u_lfsr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (lfsr_load),
      .step      (lfsr_step),
      .state_q   (lfsr_q),
      .state_nxt (lfsr_nxt)
   );

   rx_bist_diff_cnt #(.LIMIT(ABORT_LIM)) u_diff (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (diff_clr),
      .inc   (diff_inc),
      .dec   (diff_dec),
      .hit   (diff_hit),
      .cnt_q (diff_cnt)
   );

   if (WSYNC_LEN > 0) begin : g_skip
      localparam int SW = (WSYNC_LEN > 1) ? $clog2(WSYNC_LEN) : 1;
      logic [SW-1:0] skip_q;

      assign skip_done = (skip_q == SW'(WSYNC_LEN - 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            skip_q <= '0;
         else if (bist_en && state_q == ST_SKIP && chr_vld)
            skip_q <= skip_done ? '0 : skip_q + 1'b1;
         else if (state_q != ST_SKIP)
            skip_q <= '0;
      end

      // R7: the skip counter stays within the word-sync window
      a_r7_skip_bound: assert property (@(posedge clk) disable iff (!rst_n)
         int'(skip_q) < WSYNC_LEN);
   end else begin : g_noskip
      assign skip_done = 1'b1;
   end

   always_comb begin
      state_d   = state_q;
      err_d     = err_q;
      lfsr_load = 1'b0;
      lfsr_step = 1'b0;
      diff_clr  = 1'b0;
      diff_inc  = 1'b0;
      diff_dec  = 1'b0;
      code_d    = STS_GOOD;
      if (!bist_en) begin
         state_d   = ST_OFF;
         err_d     = 1'b0;
         lfsr_load = 1'b1;
         diff_clr  = 1'b1;
         code_d    = STS_OFF;
      end else begin
         unique case (state_q)
            ST_OFF, ST_HUNT: begin
               state_d = ST_HUNT;
               code_d  = STS_HUNT;
               if (chr_vld && is_start) begin
                  state_d   = ST_RUN;
                  lfsr_step = 1'b1;
                  err_d     = 1'b0;
                  code_d    = STS_GOOD;
               end
            end
            ST_RUN: begin
               if (chr_vld) begin
                  diff_inc = !is_match;
                  diff_dec = is_match;
                  if (!is_match && diff_hit) begin
                     state_d   = ST_HUNT;
                     lfsr_load = 1'b1;
                     diff_clr  = 1'b1;
                     err_d     = 1'b0;
                     code_d    = STS_MISS;
                  end else begin
                     lfsr_step = 1'b1;
                     if (loop_last) begin
                        code_d  = (err_q || !is_match) ? STS_FAILED : STS_PASS;
                        err_d   = 1'b0;
                        state_d = (WSYNC_LEN > 0) ? ST_SKIP : ST_RUN;
                     end else begin
                        code_d = is_match ? STS_GOOD : STS_MISS;
                        err_d  = err_q || !is_match;
                     end
                  end
               end
            end
            ST_SKIP: begin
               code_d = STS_GOOD;
               if (chr_vld && skip_done)
                  state_d = ST_RUN;
            end
            default: state_d = ST_HUNT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_OFF;
         err_q     <= 1'b0;
         stat_vld  <= 1'b0;
         stat_code <= STS_OFF;
      end else begin
         state_q  <= state_d;
         err_q    <= err_d;
         stat_vld <= chr_vld;
         if (chr_vld)
            stat_code <= code_d;
      end
   end

   // R9: every accepted character yields one status strobe
   a_r9_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
      chr_vld |=> stat_vld);
   // R9: no strobe without a character
   a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !chr_vld |=> !stat_vld);
   // R1: disabled self-test reports the off code
   a_r1_off_code: assert property (@(posedge clk) disable iff (!rst_n)
      (!bist_en && chr_vld) |=> (stat_code == STS_OFF));
   // R2: the generator waits at its seed while hunting
   a_r2_hunt_seed: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HUNT) |-> (lfsr_q == SEED));
   // R7: skipped characters always read as good
   a_r7_skip_good: assert property (@(posedge clk) disable iff (!rst_n)
      (bist_en && state_q == ST_SKIP && chr_vld) |=> (stat_code == STS_GOOD));
   // R8: an abort returns to hunting with a cleared difference
   a_r8_abort_hunt: assert property (@(posedge clk) disable iff (!rst_n)
      (bist_en && state_q == ST_RUN && chr_vld && !is_match && diff_hit)
      |=> (state_q == ST_HUNT && diff_cnt == '0 && stat_code == STS_MISS));

endmodule

// File: tb/rx_bist_checker_tb.sv
module rx_bist_checker_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bist_en = 1'b0;
   logic       chr_vld = 1'b0;
   logic [7:0] chr_data = '0;
   logic       chr_is_k = 1'b0;
   logic       chr_viol = 1'b0;
   logic       stat_vld;
   logic [2:0] stat_code;

   int         n_chk = 0;
   int         n_fail = 0;
   bit         done = 1'b0;
   logic [8:0] m_s = 9'h1FF;

   always #2 clk = ~clk;

   rx_bist_checker u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bist_en   (bist_en),
      .chr_vld   (chr_vld),
      .chr_data  (chr_data),
      .chr_is_k  (chr_is_k),
      .chr_viol  (chr_viol),
      .stat_vld  (stat_vld),
      .stat_code (stat_code)
   );

   function automatic logic [8:0] gen_next(input logic [8:0] s);
      return {s[7:0], s[8] ^ s[4]};
   endfunction

   task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", tag, got, exp);
      end
   endtask

   // drive at a falling edge, check status at the next falling edge
   task automatic send(input logic k, input logic [7:0] d, input logic v,
                       input logic [2:0] exp, input string tag);
      chr_vld = 1'b1; chr_is_k = k; chr_data = d; chr_viol = v;
      @(posedge clk);
      @(negedge clk);
      chr_vld = 1'b0;
      check(tag, {stat_vld, stat_code}, {1'b1, exp});
   endtask

   // send the expected sequence character, optionally corrupted or flagged
   task automatic send_seq(input bit corrupt, input bit viol,
                           input logic [2:0] exp, input string tag);
      logic [8:0] w;
      w = ~m_s;
      if (corrupt) w[0] = ~w[0];
      if (viol) w = w ^ 9'h0A5;
      send(w[8], w[7:0], viol, exp, tag);
      m_s = gen_next(m_s);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R10 reset", {stat_vld, stat_code}, {1'b0, 3'b111});
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 idle after reset", {stat_vld, stat_code}, {1'b0, 3'b111});
   endtask

   task automatic t_disabled();
      send(1'b0, 8'h00, 1'b0, 3'b111, "R1 D0.0 while off");
      send(1'b1, 8'hBC, 1'b0, 3'b111, "R1 K char while off");
      @(negedge clk);
      check("R9 no strobe in gap", {3'b0, stat_vld}, 4'd0);
   endtask

   task automatic t_hunt();
      bist_en = 1'b1;
      send(1'b1, 8'hBC, 1'b0, 3'b001, "R2 hunt K char");
      send(1'b0, 8'h4A, 1'b0, 3'b001, "R2 hunt data char");
      send(1'b0, 8'h00, 1'b1, 3'b001, "R2 flagged D0.0 ignored");
   endtask

   task automatic t_clean_loop();
      m_s = 9'h1FF;
      send_seq(1'b0, 1'b0, 3'b000, "R3 start code locks");
      for (int i = 1; i < 510; i++)
         send_seq(1'b0, 1'b0, 3'b000, "R4 clean match");
      send_seq(1'b0, 1'b0, 3'b010, "R6 clean loop end");
      check("R3 model wrapped", {3'b0, m_s == 9'h1FF}, 4'd1);
   endtask

   task automatic t_skip();
      for (int i = 0; i < 16; i++)
         send(i[0], 8'(i * 37 + 5), 1'b0, 3'b000, "R7 word sync skipped");
   endtask

   task automatic t_dirty_loop();
      send_seq(1'b0, 1'b0, 3'b000, "R7 next loop D0.0 compared");
      for (int i = 1; i < 510; i++) begin
         if (i == 5 || i == 200)
            send_seq(1'b1, 1'b0, 3'b101, "R4 mismatch");
         else if (i == 7 || i == 300)
            send_seq(1'b0, 1'b1, 3'b000, "R5 violation not an error");
         else
            send_seq(1'b0, 1'b0, 3'b000, "R4 match after error");
      end
      send_seq(1'b0, 1'b0, 3'b100, "R6 errored loop end");
   endtask

   task automatic t_abort();
      send_seq(1'b0, 1'b0, 3'b000, "R8 loop start");
      for (int i = 0; i < 3; i++)
         send_seq(1'b0, 1'b0, 3'b000, "R8 matches at zero");
      for (int i = 0; i < 15; i++)
         send_seq(1'b1, 1'b0, 3'b101, "R8 mismatch below limit");
      send_seq(1'b1, 1'b0, 3'b101, "R8 mismatch at limit");
      send_seq(1'b0, 1'b0, 3'b001, "R8 back to hunt");
      send(1'b0, 8'h00, 1'b0, 3'b000, "R2 relock on D0.0");
      m_s = gen_next(9'h1FF);
      send_seq(1'b0, 1'b0, 3'b000, "R3 first char after relock");
   endtask

   task automatic t_disable_mid();
      bist_en = 1'b0;
      send(1'b0, 8'h12, 1'b0, 3'b111, "R1 off mid-run");
      bist_en = 1'b1;
      send(1'b0, 8'h12, 1'b0, 3'b001, "R1 re-enable hunts");
   endtask

   initial begin
      t_reset();
      t_disabled();
      t_hunt();
      t_clean_loop();
      t_skip();
      t_dirty_loop();
      t_skip();
      t_abort();
      t_disable_mid();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule